// File: doc/BRIEF.md
# NAND Flash Opcode Sequencer

This block drives an 8-bit NAND flash device by running a short program of 4-bit opcodes supplied by software. It does not build read or program flows into hardware. Software fills up to eight opcode slots and presents four command bytes, a column address, a page address, an address-length code, a page-size bit and a data byte count. It then pulses `start`. The sequencer walks the slots in order and emits command-latch cycles, address-latch cycles, data write and data read cycles, and waits on the device ready line. When the program ends, it pulses `done`.

Data moves through a local byte buffer. While the sequencer is idle, the host preloads the buffer through a write port and reads results back through a combinational read port. A single data pointer starts at buffer address 0 on each `start` and advances by one for every data byte moved, whether written or read, across the whole program.

Every byte cycle uses one strobe, on write-enable or read-enable. The strobe's low and high widths come from two small counters. A wait for ready that lasts past a programmable limit aborts the program and raises a sticky timeout flag.

Top module: `nseq_top`

## Requirements
- R1: After `start`, slot 0 runs first and the slots run in order. The program ends at the first slot holding opcode 0000, or after slot 7 if no slot holds 0000. At the end `done` pulses for one cycle and `busy` falls. Slot k is `op_list[4k+3:4k]`.
- R2: Opcodes 0100, 0101, 0110 and 0111 each send command byte 0, 1, 2 or 3 in one write-enable cycle, with `nand_cle` high and `nand_ale` low. Command byte k is `cmd_bytes[8k+7:8k]`. `nand_cle` and `nand_ale` are never high together.
- R3: Opcode 0001 sends the column address with `nand_ale` high. With `large_page`=0 it sends one byte, `col_addr[7:0]`. With `large_page`=1 it sends that byte and then `col_addr[15:8]`.
- R4: Opcode 0010 sends the page address with `nand_ale` high, least significant byte first. `addr_len` values 0, 1 and 2 send 1, 2 and 3 bytes. A value of 3 also sends 3 bytes.
- R5: Opcode 0011 sends one address byte taken from `user_addr`, with `nand_ale` high.
- R6: Opcode 1000 writes `byte_cnt` data bytes and opcode 1001 writes one data byte. Each byte comes from the buffer at the data pointer, and the pointer then advances. `nand_cle` and `nand_ale` stay low for these bytes.
- R7: Opcode 1010 reads `byte_cnt` bytes and opcode 1011 reads one byte, each on a read-enable cycle. Each byte is stored in the buffer at the data pointer. `nand_dq_oe` is low whenever read-enable is low.
- R8: Opcodes 1100, 1101, 1110 and 1111 first wait until the synchronized `nand_rb` shows ready, and no earlier than a guard window after the wait begins. They then send command byte 0, send command byte 1, read `byte_cnt` bytes, or read one byte.
- R9: Each strobe stays low for `lo_len`+1 clocks. Between strobes in one program the strobe stays high for at least `hi_len`+1 clocks. Chip enable is low during every strobe, and `nand_dq_out` is stable while write-enable is low.
- R10: If ready has not appeared after `wait_limit` cycles of waiting, `err_timeout` is set, the program stops and `done` pulses. The next `start` clears `err_timeout`.
- R11: After reset, chip enable, write-enable and read-enable are high. `nand_cle`, `nand_ale`, `nand_dq_oe`, `busy`, `done` and `err_timeout` are low.
- R12: A counted data opcode with `byte_cnt`=0 moves no byte. Execution then continues with the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the program |
| op_list | input | 4*SLOTS | Opcode slots, slot k at bits 4k+3:4k |
| cmd_bytes | input | 32 | Command bytes 0 to 3 |
| col_addr | input | 16 | Column address |
| page_addr | input | 24 | Block/page address |
| addr_len | input | 2 | Page-address length code |
| large_page | input | 1 | 1 selects the two-byte column address |
| user_addr | input | 8 | Byte sent by opcode 0011 |
| byte_cnt | input | CNT_W | Byte count for counted data opcodes |
| lo_len | input | TW | Strobe low width minus one |
| hi_len | input | TW | Minimum strobe high width minus one |
| wait_limit | input | TMO_W | Ready wait limit in cycles |
| host_we | input | 1 | Host buffer write (only while idle) |
| host_addr | input | AW | Host buffer address |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Buffer contents at host_addr |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_out | output | 8 | Byte driven toward the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| err_timeout | output | 1 | Sticky ready-wait timeout flag |

## Verification
The hardest behaviour to reach from the ports is the ready wait. That wait only means something if the device goes busy right after a command and stays busy for a while. The bench therefore contains a device model that latches every write-enable edge. When the model latches command byte 0x30 or 0x10, it pulls ready low for a chosen number of cycles. With that model, the page-read and program lists from the vector table have to hold off and then resume. A directed run keeps the device busy indefinitely to force the timeout abort, and a following empty program shows that the flag clears.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [2:0] {
    K_CMD, K_COL, K_PAGE, K_USER, K_WDATA, K_RDATA
  } kind_e;

  typedef enum logic [2:0] {
    C_IDLE, C_FETCH, C_WAIT, C_ISSUE, C_XFER
  } cstate_e;

  typedef enum logic [1:0] {
    S_IDLE, S_LOW, S_HIGH
  } sstate_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] csel;     // command byte index
    logic       wait_rdy; // wait for ready first
    logic       multi;    // counted transfer
    logic       stop;     // end of program
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [3:0] op);
    op_dec_t d;
    d.kind     = K_CMD;
    d.csel     = 2'd0;
    d.wait_rdy = 1'b0;
    d.multi    = 1'b0;
    d.stop     = 1'b0;
    casez (op)
      4'b0000: d.stop = 1'b1;
      4'b0001: d.kind = K_COL;
      4'b0010: d.kind = K_PAGE;
      4'b0011: d.kind = K_USER;
      4'b01??: begin d.kind = K_CMD; d.csel = op[1:0]; end
      4'b100?: begin d.kind = K_WDATA; d.multi = ~op[0]; end
      4'b101?: begin d.kind = K_RDATA; d.multi = ~op[0]; end
      4'b110?: begin d.kind = K_CMD; d.csel = {1'b0, op[0]}; d.wait_rdy = 1'b1; end
      default: begin d.kind = K_RDATA; d.multi = ~op[0]; d.wait_rdy = 1'b1; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/nseq_strobe.sv
module nseq_strobe
  import nseq_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [TW-1:0] lo_len,
  input  logic [TW-1:0] hi_len,
  output logic          strobe_n,
  output logic          sample,
  output logic          fin
);

  sstate_e       st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sample = 1'b0;
    fin    = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (go) begin
          st_d  = S_LOW;
          cnt_d = '0;
        end
      end
      S_LOW: begin
        if (cnt_q == lo_len) begin
          sample = 1'b1;
          st_d   = S_HIGH;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_HIGH: begin
        if (cnt_q == hi_len) begin
          fin  = 1'b1;
          st_d = S_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign strobe_n = (st_q != S_LOW);

  // R9: a new byte cycle is only requested once the previous one has ended
  p_go_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q == S_IDLE));

  // R9: the strobe falls only in answer to a request
  p_fall_on_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> $past(go));

endmodule

// File: rtl/nseq_buf.sv
module nseq_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [7:0]    seq_wdata,
  output logic [7:0]    seq_rdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata
);

  logic [7:0] mem [DEPTH];

  // sequencer port wins; host writes are only legal while idle
  always_ff @(posedge clk) begin
    if (seq_we) begin
      mem[seq_addr] <= seq_wdata;
    end else if (host_we) begin
      mem[host_addr] <= host_wdata;
    end
  end

  assign seq_rdata  = mem[seq_addr];
  assign host_rdata = mem[host_addr];

endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
  import nseq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int AW    = 6,
  parameter int CNT_W = 7,
  parameter int TMO_W = 16,
  parameter int GUARD = 4,
  localparam int SLOT_W = $clog2(SLOTS) + 1,
  localparam int OPL_W  = SLOTS * 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPL_W-1:0] op_list,
  input  logic [31:0]      cmd_bytes,
  input  logic [15:0]      col_addr,
  input  logic [23:0]      page_addr,
  input  logic [1:0]       addr_len,
  input  logic             large_page,
  input  logic [7:0]       user_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [TMO_W-1:0] wait_limit,
  input  logic             nand_rb,
  output logic             go,
  input  logic             fin,
  input  logic             sample,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_rdata,
  output logic             seq_we,
  output logic             cle,
  output logic             ale,
  output logic             dq_oe,
  output logic [7:0]       dq_out,
  output logic             ce_n,
  output logic             rd_sel,
  output logic             busy,
  output logic             done,
  output logic             err
);

  cstate_e          st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  kind_e            kind_q, kind_d;
  logic [1:0]       csel_q, csel_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] bidx_q, bidx_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [TMO_W-1:0] tmr_q, tmr_d;
  logic             rd_q, rd_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             rb_s1_q, rb_s2_q;

  op_dec_t          dec;
  logic [CNT_W-1:0] fetch_total;
  logic             active;
  logic             is_data;

  assign dec = decode_op(op_list[slot_q[SLOT_W-2:0]*4 +: 4]);

  always_comb begin
    unique case (dec.kind)
      K_COL:   fetch_total = large_page ? CNT_W'(2) : CNT_W'(1);
      K_PAGE:  fetch_total = (addr_len == 2'd0) ? CNT_W'(1) :
                             (addr_len == 2'd1) ? CNT_W'(2) : CNT_W'(3);
      default: fetch_total = dec.multi ? byte_cnt : CNT_W'(1);
    endcase
  end

  assign is_data = (kind_q == K_WDATA) || (kind_q == K_RDATA);

  // next-state process
  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    kind_d  = kind_q;
    csel_d  = csel_q;
    total_d = total_q;
    bidx_d  = bidx_q;
    ptr_d   = ptr_q;
    tmr_d   = tmr_q;
    rd_d    = rd_q;
    err_d   = err_q;
    done_d  = 1'b0;
    go      = 1'b0;
    unique case (st_q)
      C_IDLE: begin
        if (start) begin
          slot_d = '0;
          ptr_d  = '0;
          err_d  = 1'b0;
          st_d   = C_FETCH;
        end
      end
      C_FETCH: begin
        if ((slot_q == SLOT_W'(SLOTS)) || dec.stop) begin
          done_d = 1'b1;
          st_d   = C_IDLE;
        end else begin
          kind_d  = dec.kind;
          csel_d  = dec.csel;
          rd_d    = (dec.kind == K_RDATA);
          total_d = fetch_total;
          bidx_d  = '0;
          tmr_d   = '0;
          if (fetch_total == '0) begin
            slot_d = slot_q + 1'b1;
          end else if (dec.wait_rdy) begin
            st_d = C_WAIT;
          end else begin
            st_d = C_ISSUE;
          end
        end
      end
      C_WAIT: begin
        tmr_d = tmr_q + 1'b1;
        if (rb_s2_q && (tmr_q >= TMO_W'(GUARD))) begin
          st_d = C_ISSUE;
        end else if (tmr_q == wait_limit) begin
          err_d  = 1'b1;
          done_d = 1'b1;
          st_d   = C_IDLE;
        end
      end
      C_ISSUE: begin
        go   = 1'b1;
        st_d = C_XFER;
      end
      C_XFER: begin
        if (fin) begin
          if (is_data) ptr_d = ptr_q + 1'b1;
          if (bidx_q + 1'b1 == total_q) begin
            slot_d = slot_q + 1'b1;
            st_d   = C_FETCH;
          end else begin
            bidx_d = bidx_q + 1'b1;
            st_d   = C_ISSUE;
          end
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      slot_q  <= '0;
      kind_q  <= K_CMD;
      csel_q  <= '0;
      total_q <= '0;
      bidx_q  <= '0;
      ptr_q   <= '0;
      tmr_q   <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rb_s1_q <= 1'b0;
      rb_s2_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      kind_q  <= kind_d;
      csel_q  <= csel_d;
      total_q <= total_d;
      bidx_q  <= bidx_d;
      ptr_q   <= ptr_d;
      tmr_q   <= tmr_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rb_s1_q <= nand_rb;
      rb_s2_q <= rb_s1_q;
    end
  end

  assign active = (st_q == C_ISSUE) || (st_q == C_XFER);

  always_comb begin
    unique case (kind_q)
      K_CMD:   dq_out = cmd_bytes[csel_q*8 +: 8];
      K_COL:   dq_out = (bidx_q == '0) ? col_addr[7:0] : col_addr[15:8];
      K_PAGE: begin
        unique case (bidx_q[1:0])
          2'd0:    dq_out = page_addr[7:0];
          2'd1:    dq_out = page_addr[15:8];
          default: dq_out = page_addr[23:16];
        endcase
      end
      K_USER:  dq_out = user_addr;
      K_WDATA: dq_out = buf_rdata;
      default: dq_out = 8'h00;
    endcase
  end

  assign cle      = active && (kind_q == K_CMD);
  assign ale      = active && ((kind_q == K_COL) || (kind_q == K_PAGE) || (kind_q == K_USER));
  assign dq_oe    = active && !rd_q;
  assign seq_we   = sample && (st_q == C_XFER) && rd_q;
  assign buf_addr = ptr_q;
  assign rd_sel   = rd_q;
  assign ce_n     = (st_q == C_IDLE);
  assign busy     = (st_q != C_IDLE);
  assign done     = done_q;
  assign err      = err_q;

  // R2: command and address latches are exclusive
  p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R1: the end pulse follows a running program
  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);

  // R10: the timeout flag can only be raised out of a ready wait
  p_err_from_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(st_q == C_WAIT));

  // R1: the slot index never runs past the last slot
  p_slot_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SLOT_W'(SLOTS));

endmodule

// File: rtl/nseq_top.sv
module nseq_top
  import nseq_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int BUF_DEPTH = 64,
  parameter int TW        = 3,
  parameter int TMO_W     = 16,
  parameter int RB_GUARD  = 4,
  localparam int AW    = $clog2(BUF_DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SLOTS*4-1:0] op_list,
  input  logic [31:0]        cmd_bytes,
  input  logic [15:0]        col_addr,
  input  logic [23:0]        page_addr,
  input  logic [1:0]         addr_len,
  input  logic               large_page,
  input  logic [7:0]         user_addr,
  input  logic [CNT_W-1:0]   byte_cnt,
  input  logic [TW-1:0]      lo_len,
  input  logic [TW-1:0]      hi_len,
  input  logic [TMO_W-1:0]   wait_limit,
  input  logic               host_we,
  input  logic [AW-1:0]      host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [7:0]         nand_dq_out,
  output logic               nand_dq_oe,
  input  logic [7:0]         nand_dq_in,
  input  logic               nand_rb,
  output logic               busy,
  output logic               done,
  output logic               err_timeout
);

  logic          rst_s1_q, rst_sync_n;
  logic          go, fin, sample, strobe_n, rd_sel, seq_we;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_rdata;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  nseq_ctrl #(
    .SLOTS(SLOTS), .AW(AW), .CNT_W(CNT_W), .TMO_W(TMO_W), .GUARD(RB_GUARD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .op_list(op_list),
    .cmd_bytes(cmd_bytes), .col_addr(col_addr), .page_addr(page_addr),
    .addr_len(addr_len), .large_page(large_page), .user_addr(user_addr),
    .byte_cnt(byte_cnt), .wait_limit(wait_limit), .nand_rb(nand_rb),
    .go(go), .fin(fin), .sample(sample), .buf_addr(buf_addr),
    .buf_rdata(buf_rdata), .seq_we(seq_we), .cle(nand_cle), .ale(nand_ale),
    .dq_oe(nand_dq_oe), .dq_out(nand_dq_out), .ce_n(nand_ce_n),
    .rd_sel(rd_sel), .busy(busy), .done(done), .err(err_timeout)
  );

  nseq_strobe #(.TW(TW)) u_strobe (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .lo_len(lo_len), .hi_len(hi_len),
    .strobe_n(strobe_n), .sample(sample), .fin(fin)
  );

  nseq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .seq_we(seq_we), .seq_addr(buf_addr), .seq_wdata(nand_dq_in),
    .seq_rdata(buf_rdata), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  assign nand_we_n = strobe_n | rd_sel;
  assign nand_re_n = strobe_n | ~rd_sel;

  // R9: every strobe falls inside chip enable
  p_strobe_in_ce_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R7: the data bus is released during reads
  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !nand_re_n |-> !nand_dq_oe);

  // R9: written byte held steady while write-enable is low
  p_dq_stable_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_out));

  // R7: host writes must not collide with sequencer reads
  p_one_writer_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(seq_we && host_we));

endmodule

// File: tb/sim_nseq_top.sv
`timescale 1ns/1ps
module sim_nseq_top;

  localparam logic [15:0] COL  = 16'h0823;
  localparam logic [23:0] PAGE = 24'h041D7A;
  localparam logic [7:0]  USR  = 8'h5C;
  localparam logic [7:0]  SEED = 8'h3C;
  localparam int NVEC = 5;
  // fields: op[79:48] cmd[47:16] large[15] alen[14:13] bcnt[12:6] lo[5:3] hi[2:0]
  localparam logic [79:0] VECS [NVEC] = '{
    {32'h000E5214, 32'h00003000, 1'b1, 2'd2, 7'd8, 3'd1, 3'd0},
    {32'h0BC68215, 32'h00108070, 1'b0, 2'd1, 7'd5, 3'd0, 3'd1},
    {32'h74FB1993, 32'h44332211, 1'b1, 2'd0, 7'd3, 3'd2, 3'd2},
    {32'h000004A8, 32'h00000055, 1'b0, 2'd3, 7'd0, 3'd0, 3'd0},
    {32'h00000000, 32'h00000000, 1'b0, 2'd0, 7'd4, 3'd1, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_list = '0;
  logic [31:0] cmd_bytes = '0;
  logic [1:0]  addr_len = '0;
  logic        large_page = 1'b0;
  logic [6:0]  byte_cnt = '0;
  logic [2:0]  lo_len = '0;
  logic [2:0]  hi_len = '0;
  logic [15:0] wait_limit = 16'd1000;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  dq_in = '0;
  logic        rb = 1'b1;
  logic        busy, done, err_timeout;

  always #4 clk = ~clk;

  nseq_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_list(op_list),
    .cmd_bytes(cmd_bytes), .col_addr(COL), .page_addr(PAGE),
    .addr_len(addr_len), .large_page(large_page), .user_addr(USR),
    .byte_cnt(byte_cnt), .lo_len(lo_len), .hi_len(hi_len),
    .wait_limit(wait_limit), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(dq_in), .nand_rb(rb), .busy(busy), .done(done),
    .err_timeout(err_timeout)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model (acts on falling edges) ----------------
  int         run_id = 0;
  int         last_id = 0;
  int         busy_len = 20;
  logic [9:0] dev_log [64];
  int         dev_n = 0;
  int         busy_left = 0;
  int         rcnt = 0;
  int         lowrun = 0;
  int         highrun = 0;
  int         viol = 0;
  bit         seen = 0;
  logic       p_we = 1'b1, p_re = 1'b1, p_st = 1'b1;

  always @(negedge clk) begin
    if (run_id != last_id) begin
      last_id = run_id; dev_n = 0; busy_left = 0; rcnt = 0;
      lowrun = 0; highrun = 0; viol = 0; seen = 0;
    end
    if (rst_n) begin
      if (busy_left > 0) busy_left--;
      if (!p_we && nand_we_n) begin
        if (dev_n < 64) dev_log[dev_n] = {nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2), nand_dq_out};
        dev_n++;
        if (nand_cle && (nand_dq_out == 8'h30 || nand_dq_out == 8'h10)) busy_left = busy_len;
      end
      if (p_re && !nand_re_n) dq_in = SEED + 8'(rcnt);
      if (!p_re && nand_re_n) begin
        if (dev_n < 64) dev_log[dev_n] = {2'd3, dq_in};
        dev_n++;
        rcnt++;
      end
      rb = (busy_left == 0);
      if (!(nand_we_n & nand_re_n)) begin
        if (p_st && seen && (highrun < int'(hi_len) + 1)) viol++;
        lowrun++;
        highrun = 0;
      end else begin
        if (!p_st) begin
          if (lowrun != int'(lo_len) + 1) viol++;
          seen = 1;
        end
        lowrun = 0;
        if (!nand_ce_n) highrun++; else seen = 0;
      end
      p_we = nand_we_n; p_re = nand_re_n; p_st = nand_we_n & nand_re_n;
    end
  end

  // ---------------- expected-value model ----------------
  logic [9:0] exp_log [64];
  int         exp_n;
  logic [7:0] exp_buf [64];

  function automatic logic [7:0] init_byte(input int i);
    return 8'hA0 ^ 8'(i * 7);
  endfunction

  task automatic add_exp(input logic [1:0] t, input logic [7:0] v);
    if (exp_n < 64) exp_log[exp_n] = {t, v};
    exp_n++;
  endtask

  task automatic build_exp(input logic [31:0] opl, input logic [31:0] cmd, input logic lg,
                           input logic [1:0] al, input logic [6:0] bc);
    int ptr = 0;
    int rd = 0;
    exp_n = 0;
    for (int i = 0; i < 64; i++) exp_buf[i] = init_byte(i);
    for (int s = 0; s < 8; s++) begin
      logic [3:0] op = opl[s*4 +: 4];
      if (op == 4'b0000) break;
      if (op == 4'b0001) begin                      // R3
        add_exp(2'd1, COL[7:0]);
        if (lg) add_exp(2'd1, COL[15:8]);
      end else if (op == 4'b0010) begin             // R4
        int k = (al == 2'd0) ? 1 : (al == 2'd1) ? 2 : 3;
        for (int j = 0; j < k; j++) add_exp(2'd1, PAGE[j*8 +: 8]);
      end else if (op == 4'b0011) begin             // R5
        add_exp(2'd1, USR);
      end else if (op[3:2] == 2'b01) begin          // R2
        add_exp(2'd0, cmd[op[1:0]*8 +: 8]);
      end else if (op[3:1] == 3'b110) begin         // R8
        add_exp(2'd0, cmd[op[0]*8 +: 8]);
      end else if (op[3:1] == 3'b100) begin         // R6, R12
        int c = op[0] ? 1 : int'(bc);
        for (int j = 0; j < c; j++) begin add_exp(2'd2, exp_buf[ptr % 64]); ptr++; end
      end else begin                                // R7, R8, R12
        int c = op[0] ? 1 : int'(bc);
        for (int j = 0; j < c; j++) begin
          exp_buf[ptr % 64] = SEED + 8'(rd);
          add_exp(2'd3, SEED + 8'(rd));
          ptr++; rd++;
        end
      end
    end
  endtask

  // ---------------- helpers ----------------
  task automatic load_buf();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = 6'(i); host_wdata = init_byte(i);
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run_prog(output bit got_done);
    got_done = 0;
    @(negedge clk);
    run_id++;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin got_done = 1; break; end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_log(input string req);
    int bad = 0;
    chk(dev_n == exp_n, {req, " byte count"}, 32'(dev_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < dev_n && i < 64; i++)
      if (dev_log[i] != exp_log[i]) begin
        bad++;
        $display("  slot byte %0d: actual=%0h expected=%0h", i, dev_log[i], exp_log[i]);
      end
    chk(bad == 0, {req, " byte contents"}, 32'(bad), 32'd0);
  endtask

  task automatic cmp_buf(input string req);
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      host_addr = 6'(i);
      #1;
      if (host_rdata != exp_buf[i]) bad++;
    end
    chk(bad == 0, {req, " buffer"}, 32'(bad), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, busy, done, err_timeout}
        == 9'b111000000, "R11 reset outputs",
        32'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, busy, done, err_timeout}),
        32'h1C0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && nand_ce_n, "R11 idle after reset", 32'({busy, nand_ce_n}), 32'h1);

    // table-driven programs: R1..R9, R12
    for (int v = 0; v < NVEC; v++) begin
      op_list    = VECS[v][79:48];
      cmd_bytes  = VECS[v][47:16];
      large_page = VECS[v][15];
      addr_len   = VECS[v][14:13];
      byte_cnt   = VECS[v][12:6];
      lo_len     = VECS[v][5:3];
      hi_len     = VECS[v][2:0];
      wait_limit = 16'd1000;
      busy_len   = 20;
      load_buf();
      build_exp(op_list, cmd_bytes, large_page, addr_len, byte_cnt);
      run_prog(ok);
      chk(ok && !busy, $sformatf("R1 vector %0d done", v), 32'({ok, busy}), 32'h2);
      cmp_log($sformatf("R2/R3/R4/R5/R6/R7/R8/R12 vector %0d", v));
      cmp_buf($sformatf("R6/R7 vector %0d", v));
      chk(viol == 0, $sformatf("R9 vector %0d strobe widths", v), 32'(viol), 32'd0);
      chk(!err_timeout, $sformatf("R10 vector %0d no timeout", v), 32'(err_timeout), 32'd0);
    end

    // R10: device stays busy, wait gives up
    op_list    = 32'h0000_00E4;
    cmd_bytes  = 32'h0000_0030;
    byte_cnt   = 7'd2;
    wait_limit = 16'd40;
    busy_len   = 100000;
    run_prog(ok);
    chk(ok && err_timeout, "R10 timeout flagged", 32'({ok, err_timeout}), 32'h3);
    chk(dev_n == 1, "R10 program aborted after command", 32'(dev_n), 32'd1);
    chk(!busy && nand_ce_n, "R10 idle after abort", 32'({busy, nand_ce_n}), 32'h1);

    // R10: next start clears the flag
    op_list  = 32'h0;
    busy_len = 0;
    run_prog(ok);
    chk(ok && !err_timeout, "R10 flag cleared by start", 32'({ok, err_timeout}), 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule